// File: doc/BRIEF.md
# Single-Channel DMA Controller with Bus Handoff

The controller moves a block of words between one peripheral and memory without the processor copying each word. The processor programs three registers: the first memory location, the number of words, and a control word. The control word picks the direction, picks the release policy and carries a start bit. Once started, the controller raises a bus request. From the moment the system arbiter returns bus grant, the controller is a bus master. It drives the memory address and one read or write strobe for each word. Words pass straight through between the memory data lines and the peripheral data lines.

Bus grant decides which role the block plays. With grant low, the block is a slave register file on the processor bus. With grant high, the processor port is closed and the block owns memory. There are two release policies. In burst mode the bus is held until the last word has moved. In cycle-stealing mode the bus is given back after every word and requested again for the next one. A sticky completion flag, also driven on the interrupt pin, tells the processor the block is done.

The peripheral side follows a valid/ready handshake. `dev_req` is the peripheral's valid: it is ready to exchange one word. `dev_ack` is the controller's ready, and it pulses in the cycle the word moves. The peripheral applies back-pressure by holding `dev_req` low. Nothing moves and the state does not change, but in burst mode the bus stays held through the stall. `dev_req` may stay high across several words, and each cycle with `dev_ack` high is exactly one word.

Top module: `dma_ctrl`

## Requirements
- R1: After reset, all three registers read zero, and `bus_req`, `mem_rd`, `mem_wr`, `dev_ack` and `irq` are low.
- R2: Only with `cpu_cs` high and `bus_grant` low can the processor reach the registers. `cpu_sel` picks the register: 0 is the address, 1 is the word count, 2 is control, and 3 reads as zero. Control bits are: bit 0 start, bit 1 direction (1 = peripheral to memory, 0 = memory to peripheral), bit 2 policy (1 = cycle stealing, 0 = burst), bit 3 completion flag. `cpu_rdata` is zero whenever `bus_grant` is high, and writes made while granted are dropped.
- R3: A control write that sets start with a non-zero count raises `bus_req` on the clock edge after the write edge.
- R4: A word moves only in a cycle where the controller owns the bus, `bus_grant` is high and `dev_req` is high. In that cycle `dev_ack` is high together with exactly one of `mem_rd` or `mem_wr`.
- R5: Each word moved increments the address register by one and decrements the count register by one.
- R6: In burst mode, `bus_req` stays high from the grant until the last word has moved, including cycles where `dev_req` is low. One request covers the whole block.
- R7: In cycle-stealing mode, `bus_req` drops right after each word. It rises again only after `bus_grant` has fallen, so a block of N words makes N separate requests.
- R8: When the last word moves, start clears, `bus_req` drops and the completion flag (`irq`) sets. The flag stays set until a control write with bit 3 high is made while no transfer is active.
- R9: Setting start with a count of zero completes at once. The completion flag sets, start stays clear and `bus_req` never rises.
- R10: While start is set, writes to the address and count registers are ignored, and a control write changes nothing except clearing start. Clearing start aborts the transfer at the next word boundary: no further word moves, the bus is released and the completion flag stays clear.
- R11: In memory-to-peripheral transfers, `dev_rdata` carries the word read from `mem_addr`. In peripheral-to-memory transfers, `mem_wdata` carries `dev_wdata`. No location past the end of the block is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_cs | input | 1 | Processor selects this block |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_sel | input | 2 | Register select |
| cpu_wdata | input | DW | Processor write data |
| cpu_rdata | output | DW | Processor read data, zero when not read |
| bus_req | output | 1 | Request for the memory bus |
| bus_grant | input | 1 | Arbiter has handed over the memory bus |
| mem_addr | output | AW | Memory address of the word moving |
| mem_rd | output | 1 | Memory read strobe, one cycle per word |
| mem_wr | output | 1 | Memory write strobe, one cycle per word |
| mem_wdata | output | DW | Data written to memory |
| mem_rdata | input | DW | Data returned by memory in the same cycle |
| dev_req | input | 1 | Peripheral is ready for one word (valid) |
| dev_ack | output | 1 | A word moved this cycle (ready) |
| dev_wdata | input | DW | Word offered by the peripheral |
| dev_rdata | output | DW | Word delivered to the peripheral |
| irq | output | 1 | Sticky completion flag |

## Verification
The bound checker watches the following on every cycle: memory strobes never occur without an active grant and request, each acknowledge carries exactly one strobe, and every word steps the address and count by one. It also checks the release policy right after each word (held in burst, dropped in cycle stealing), that the completion flag is sticky, and that the processor read port stays silent while the bus is granted. Other behaviours can only be seen in the bench's scenarios. These are the number of separate requests per block, whether the data reached the right locations with nothing written past the block, and zero-length starts. They also include writes that must be ignored mid-transfer and an abort that leaves the registers where the transfer stopped. The bench sweeps lengths from one to five words over both directions and both policies, with and without peripheral stalls.

// File: rtl/dma_pkg.sv
package dma_pkg;

  // processor register select codes
  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_RSVD  = 2'd3
  } dma_sel_e;

  // control word bit positions
  localparam int unsigned CTL_RUN   = 0;
  localparam int unsigned CTL_TOMEM = 1;
  localparam int unsigned CTL_STEAL = 2;
  localparam int unsigned CTL_DONE  = 3;

  typedef struct packed {
    logic steal;   // 1: release the bus after each word
    logic to_mem;  // 1: peripheral -> memory
    logic run;     // transfer active
  } dma_ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE,   // slave only
    ST_ASK,    // bus requested, waiting for grant
    ST_OWN,    // bus master, moving words
    ST_YIELD   // request dropped, waiting for grant to fall
  } dma_state_e;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_cs,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [1:0]    cpu_sel,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          bus_grant,
  input  logic          step,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o,
  output dma_ctl_t      ctl_o,
  output logic          done_o
);

  logic          port_open;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  dma_ctl_t      ctl_q;
  logic          done_q;

  // processor port closes while the bus belongs to the controller
  assign port_open = cpu_cs && !bus_grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      ctl_q  <= '0;
      done_q <= 1'b0;
    end else if (step) begin
      addr_q <= addr_q + 1'b1;
      cnt_q  <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        ctl_q.run <= 1'b0;
        done_q    <= 1'b1;
      end
    end else if (port_open && cpu_wr) begin
      case (cpu_sel)
        SEL_ADDR:  if (!ctl_q.run) addr_q <= cpu_wdata[AW-1:0];
        SEL_COUNT: if (!ctl_q.run) cnt_q <= cpu_wdata[CW-1:0];
        SEL_CTRL: begin
          if (ctl_q.run) begin
            // only an abort gets through while active
            if (!cpu_wdata[CTL_RUN]) ctl_q.run <= 1'b0;
          end else begin
            ctl_q.to_mem <= cpu_wdata[CTL_TOMEM];
            ctl_q.steal  <= cpu_wdata[CTL_STEAL];
            if (cpu_wdata[CTL_DONE]) done_q <= 1'b0;
            if (cpu_wdata[CTL_RUN]) begin
              if (cnt_q == '0) done_q <= 1'b1;
              else             ctl_q.run <= 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (port_open && cpu_rd) begin
      case (cpu_sel)
        SEL_ADDR:  cpu_rdata = DW'(addr_q);
        SEL_COUNT: cpu_rdata = DW'(cnt_q);
        SEL_CTRL:  cpu_rdata = DW'({done_q, ctl_q.steal, ctl_q.to_mem, ctl_q.run});
        default:   cpu_rdata = '0;
      endcase
    end
  end

  assign addr_o = addr_q;
  assign cnt_o  = cnt_q;
  assign ctl_o  = ctl_q;
  assign done_o = done_q;

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic steal,
  input  logic cnt_last,
  input  logic bus_grant,
  input  logic dev_req,
  output logic bus_req,
  output logic move
);

  dma_state_e state_q, state_d;

  // one word per cycle while owning the bus and the peripheral is ready
  assign move    = (state_q == ST_OWN) && bus_grant && dev_req && run;
  assign bus_req = (state_q == ST_ASK) || (state_q == ST_OWN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (run) state_d = ST_ASK;
      ST_ASK: begin
        if (!run)           state_d = ST_IDLE;
        else if (bus_grant) state_d = ST_OWN;
      end
      ST_OWN: begin
        if (!run)                             state_d = ST_YIELD;
        else if (move && (cnt_last || steal)) state_d = ST_YIELD;
      end
      ST_YIELD: if (!bus_grant) state_d = run ? ST_ASK : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/dma_datapath.sv
module dma_datapath #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          move,
  input  logic          to_mem,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] dev_wdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] dev_rdata,
  output logic          dev_ack
);

  assign mem_addr  = move ? addr : '0;
  assign mem_rd    = move && !to_mem;
  assign mem_wr    = move && to_mem;
  assign mem_wdata = (move && to_mem)  ? dev_wdata : '0;
  assign dev_rdata = (move && !to_mem) ? mem_rdata : '0;
  assign dev_ack   = move;

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_cs,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [1:0]    cpu_sel,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          dev_req,
  output logic          dev_ack,
  input  logic [DW-1:0] dev_wdata,
  output logic [DW-1:0] dev_rdata,
  output logic          irq
);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  dma_ctl_t      ctl_q;
  logic          done_q;
  logic          step;
  logic          cnt_last;
  logic          xfer_steal;

  assign cnt_last   = (cnt_q == CW'(1));
  assign xfer_steal = ctl_q.steal;
  assign irq        = done_q;

  dma_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_cs    (cpu_cs),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_sel   (cpu_sel),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .bus_grant (bus_grant),
    .step      (step),
    .addr_o    (addr_q),
    .cnt_o     (cnt_q),
    .ctl_o     (ctl_q),
    .done_o    (done_q)
  );

  dma_engine u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctl_q.run),
    .steal     (xfer_steal),
    .cnt_last  (cnt_last),
    .bus_grant (bus_grant),
    .dev_req   (dev_req),
    .bus_req   (bus_req),
    .move      (step)
  );

  dma_datapath #(.AW(AW), .DW(DW)) u_path (
    .move      (step),
    .to_mem    (ctl_q.to_mem),
    .addr      (addr_q),
    .mem_rdata (mem_rdata),
    .dev_wdata (dev_wdata),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .dev_rdata (dev_rdata),
    .dev_ack   (dev_ack)
  );

endmodule

// File: rtl/dma_ctrl_chk.sv
module dma_ctrl_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_cs,
  input logic          cpu_wr,
  input logic [1:0]    cpu_sel,
  input logic [DW-1:0] cpu_wdata,
  input logic [DW-1:0] cpu_rdata,
  input logic          bus_req,
  input logic          bus_grant,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          dev_req,
  input logic          dev_ack,
  input logic          irq,
  input logic [AW-1:0] addr_q,
  input logic [CW-1:0] cnt_q,
  input logic          xfer_steal
);

  logic done_clear_wr;
  assign done_clear_wr = cpu_cs && cpu_wr && !bus_grant && (cpu_sel == 2'd2) && cpu_wdata[3];

  AST_STROBE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (bus_grant && bus_req)); // R4

  AST_ACK_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> ((mem_rd ^ mem_wr) && dev_req)); // R4

  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |=> ((addr_q == AW'($past(addr_q) + 1'b1)) && (cnt_q == CW'($past(cnt_q) - 1'b1)))); // R5

  AST_BURST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && !xfer_steal && (cnt_q != CW'(1))) |=> bus_req); // R6

  AST_STEAL_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && xfer_steal) |=> !bus_req); // R7

  AST_LAST_WORD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && (cnt_q == CW'(1))) |=> (irq && !bus_req)); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !done_clear_wr) |=> irq); // R8

  AST_PORT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> (cpu_rdata == '0)); // R2

endmodule

bind dma_ctrl dma_ctrl_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_cs     (cpu_cs),
  .cpu_wr     (cpu_wr),
  .cpu_sel    (cpu_sel),
  .cpu_wdata  (cpu_wdata),
  .cpu_rdata  (cpu_rdata),
  .bus_req    (bus_req),
  .bus_grant  (bus_grant),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .dev_req    (dev_req),
  .dev_ack    (dev_ack),
  .irq        (irq),
  .addr_q     (addr_q),
  .cnt_q      (cnt_q),
  .xfer_steal (xfer_steal)
);

// File: tb/dma_ctrl_tb.sv
module dma_ctrl_tb;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          cpu_cs = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [1:0]    cpu_sel = 2'd0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req;
  logic          bus_grant = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          dev_req, dev_ack;
  logic [DW-1:0] dev_wdata, dev_rdata;
  logic          irq;

  dma_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_cs(cpu_cs), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_req(dev_req), .dev_ack(dev_ack), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata), .irq(irq)
  );

  // bench-side memory, arbiter and peripheral
  logic [15:0] mem [256];
  logic [15:0] rx [8];
  logic        hold_grant = 1'b0, dreq_on = 1'b0, stall = 1'b0, clr = 1'b0;
  logic [15:0] wsrc = '0;
  int          acks = 0, rises = 0, cyc = 0;
  logic        req_d = 1'b0;
  int          vecs = 0, errs = 0;

  assign mem_rdata = mem[mem_addr[7:0]];
  assign dev_wdata = wsrc + 16'(acks);
  assign dev_req   = dreq_on && !(stall && ((cyc % 4) == 3));

  always @(posedge clk) begin
    cyc       <= cyc + 1;
    bus_grant <= bus_req && !hold_grant;
    req_d     <= bus_req;
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (clr) begin
      acks  <= 0;
      rises <= 0;
    end else begin
      if (dev_ack) begin
        rx[acks[2:0]] <= dev_rdata;
        acks <= acks + 1;
      end
      if (bus_req && !req_d) rises <= rises + 1;
    end
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    cpu_sel = s; cpu_wdata = d; cpu_cs = 1'b1; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_cs = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [15:0] d);
    @(negedge clk);
    cpu_sel = s; cpu_cs = 1'b1; cpu_rd = 1'b1;
    #1 d = cpu_rdata;
    cpu_cs = 1'b0; cpu_rd = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic wait_done();
    int g = 0;
    while (!irq && g < 1000) begin
      @(negedge clk);
      g++;
    end
    while (bus_grant) @(negedge clk);
  endtask

  function automatic logic [15:0] pat(input int base, input int i);
    return 16'h4000 + 16'(base * 8) + 16'(i);
  endfunction

  task automatic run_xfer(input int base, input int n, input logic stl_mode,
                          input logic dir, input logic stl);
    logic [15:0] v;
    for (int i = 0; i < 8; i++) mem[base + i] = pat(base, i);
    mem[base + n] = 16'hDEAD;
    wsrc = 16'h8000 + 16'(base);
    pulse_clr();
    stall = stl; dreq_on = 1'b1;
    wr_reg(2'd0, 16'(base));
    wr_reg(2'd1, 16'(n));
    wr_reg(2'd2, {13'd0, stl_mode, dir, 1'b1});
    wait_done();
    dreq_on = 1'b0;
    chk("R4 words acknowledged", 32'(acks), 32'(n));
    chk(stl_mode ? "R7 separate requests" : "R6 single request",
        32'(rises), stl_mode ? 32'(n) : 32'd1);
    rd_reg(2'd0, v); chk("R5 final address", 32'(v), 32'(base + n));
    rd_reg(2'd1, v); chk("R5 final count", 32'(v), 32'd0);
    rd_reg(2'd2, v); chk("R8 control after completion", 32'(v), {28'd0, 1'b1, stl_mode, dir, 1'b0});
    chk("R8 irq set", 32'(irq), 32'd1);
    chk("R8 bus released", 32'(bus_req), 32'd0);
    for (int i = 0; i < n; i++) begin
      if (dir) chk("R11 memory written", 32'(mem[base + i]), 32'(wsrc + 16'(i)));
      else     chk("R11 peripheral data", 32'(rx[i]), 32'(pat(base, i)));
    end
    chk("R11 no write past block", 32'(mem[base + n]), 32'h0000DEAD);
    wr_reg(2'd2, 16'h0008);
    chk("R8 flag cleared by write", 32'(irq), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog act=running exp=finished");
    report();
    $finish;
  end

  initial begin
    logic [15:0] v;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd_reg(2'd0, v); chk("R1 address reset", 32'(v), 32'd0);
    rd_reg(2'd1, v); chk("R1 count reset", 32'(v), 32'd0);
    rd_reg(2'd2, v); chk("R1 control reset", 32'(v), 32'd0);
    chk("R1 no request", 32'(bus_req), 32'd0);
    chk("R1 no strobes", 32'({mem_rd, mem_wr, dev_ack}), 32'd0);
    chk("R1 no irq", 32'(irq), 32'd0);

    // register map
    wr_reg(2'd0, 16'h1234);
    rd_reg(2'd3, v); chk("R2 reserved select reads zero", 32'(v), 32'd0);
    rd_reg(2'd0, v); chk("R2 address readback", 32'(v), 32'h1234);
    wr_reg(2'd1, 16'h0042);
    rd_reg(2'd1, v); chk("R2 count readback", 32'(v), 32'h0042);

    // zero-length start
    wr_reg(2'd1, 16'h0000);
    pulse_clr();
    wr_reg(2'd2, 16'h0001);
    repeat (5) @(negedge clk);
    chk("R9 no request for empty block", 32'(rises), 32'd0);
    chk("R9 completes at once", 32'(irq), 32'd1);
    rd_reg(2'd2, v); chk("R9 start stays clear", 32'(v), 32'h0008);
    wr_reg(2'd2, 16'h0008);

    // sweep: policy x direction x stall x length
    for (int sm = 0; sm < 2; sm++)
      for (int dr = 0; dr < 2; dr++)
        for (int st = 0; st < 2; st++)
          for (int n = 1; n <= 5; n++)
            run_xfer(16 + (sm * 4 + dr * 2 + st) * 24 + n, n, sm[0], dr[0], st[0]);

    // abort in cycle-stealing mode while waiting for the bus again
    for (int i = 0; i < 8; i++) mem[200 + i] = pat(200, i);
    pulse_clr();
    dreq_on = 1'b1; stall = 1'b0;
    wr_reg(2'd0, 16'd200);
    wr_reg(2'd1, 16'd5);
    wr_reg(2'd2, 16'h0005);
    while (acks < 1) @(negedge clk);
    hold_grant = 1'b1;
    repeat (4) @(negedge clk);
    wr_reg(2'd0, 16'h0055);
    wr_reg(2'd1, 16'h0009);
    wr_reg(2'd2, 16'h0000);
    hold_grant = 1'b0;
    repeat (10) @(negedge clk);
    dreq_on = 1'b0;
    chk("R10 no word after abort", 32'(acks), 32'd1);
    chk("R10 bus released", 32'(bus_req), 32'd0);
    chk("R10 no completion", 32'(irq), 32'd0);
    rd_reg(2'd0, v); chk("R10 address write ignored", 32'(v), 32'd201);
    rd_reg(2'd1, v); chk("R10 count write ignored", 32'(v), 32'd4);
    rd_reg(2'd2, v); chk("R10 only start cleared", 32'(v), 32'h0004);

    // request timing and closed processor port while granted
    pulse_clr();
    dreq_on = 1'b0;
    wr_reg(2'd0, 16'd100);
    wr_reg(2'd1, 16'd4);
    wr_reg(2'd2, 16'h0003);
    chk("R3 request not yet raised", 32'(bus_req), 32'd0);
    @(negedge clk);
    chk("R3 request after start", 32'(bus_req), 32'd1);
    while (!bus_grant) @(negedge clk);
    rd_reg(2'd0, v); chk("R2 read closed while granted", 32'(v), 32'd0);
    wr_reg(2'd0, 16'h0077);
    chk("R6 bus held while peripheral stalls", 32'(bus_req), 32'd1);
    dreq_on = 1'b1;
    wait_done();
    dreq_on = 1'b0;
    rd_reg(2'd0, v); chk("R2 write while granted dropped", 32'(v), 32'd104);
    chk("R4 words acknowledged", 32'(acks), 32'd4);
    wr_reg(2'd2, 16'h0008);

    report();
    $finish;
  end

endmodule